// File: doc/BRIEF.md
# PWM Channel with Selectable Clock Enable

This block is one pulse-width modulator channel. The channel holds an 8-bit period, an 8-bit pulse width, an 8-bit divider value and an 8-bit configuration byte. The configuration byte picks the enable that steps the channel counter. It can be one of four fixed-rate tick inputs, the output of an internal programmable divider, or the rising edges of a neighbouring channel's output, which lets channels be chained. Configuration bit 3 picks which output edge raises an interrupt.

The divider counts ticks of the slowest fixed-rate input, which is tick input 3. The edge interrupt is only armed when the divider source is selected and the divider value is exactly 255. An armed edge sets a sticky status bit. A read strobe clears that bit. The interrupt request is the status bit gated by a mask input. A simple write port loads the four registers. Clock generation, bus decoding and pin routing sit outside the block.

Top module: `pwm_clksel_chan`

## Requirements
- R1: After reset the output `pwm_o` is low and `int_stat_o` and `int_req_o` are 0. The configuration resets to 0x00, so the source is code 000 and falling edges are selected. The period resets to 0xFF, the width to 0x00 and the divider value to 255.
- R2: The source code is configuration bits [2:0]. Codes 000, 001, 010 and 011 select `tick_i[0]`, `tick_i[1]`, `tick_i[2]` and `tick_i[3]`. Code 100 selects the divider output and code 101 selects edges of the previous channel. With codes 110 and 111 no enable is selected and the counter holds.
- R3: The divider counts cycles where `tick_i[3]` is high. It emits one enable on every Nth such cycle, where N is the divider value, and a value of 0 acts as 1.
- R4: The counter moves only on a cycle where the selected enable is high. It goes to 0 after it reaches period−1, and a period of 0 acts as 1.
- R5: `pwm_o` is high while the counter is below the pulse width and low otherwise. A width of 0 gives a constant low output.
- R6: With source 101, each 0-to-1 change of `prev_pwm_i` between two consecutive clock samples gives exactly one enable.
- R7: Configuration bit 3 = 0 selects falling edges of `pwm_o` as the interrupt edge, and bit 3 = 1 selects rising edges. The status bit sets on the clock edge after the output transition is visible.
- R8: An edge sets the status only while the source is 100 and the divider value is 255. Under any other setting the status never sets.
- R9: `int_stat_o` stays set until a cycle with `stat_rd_i` high clears it. If a set and a clear fall in the same cycle, the set wins.
- R10: `int_req_o` is high exactly when `int_stat_o` and `int_mask_i` are both high.
- R11: A write with `wr_en_i` high loads `wr_data_i` into the register named by `wr_sel_i`. The codes are 0 = configuration, 1 = period, 2 = width and 3 = divider. The new value is in effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 4 | Fixed-rate clock enables; bit 3 also feeds the divider |
| prev_pwm_i | input | 1 | Output of the previous channel |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for the write |
| wr_data_i | input | 8 | Write data |
| stat_rd_i | input | 1 | Status read strobe; clears the status |
| int_mask_i | input | 1 | Interrupt mask; 1 enables the request |
| pwm_o | output | 1 | PWM output |
| int_stat_o | output | 1 | Sticky interrupt status |
| int_req_o | output | 1 | Masked interrupt request |

## Verification
Register writes and enable inputs act on the next clock edge. Starting from that edge, `pwm_o` shows the new count, so it is due one cycle after the stimulus. The interrupt status is due one cycle after the output transition, which makes it two cycles after the enable that caused the transition. `int_req_o` follows the status and the mask with no extra delay. The bench drives inputs just after a falling edge. It advances its own model once per rising edge and compares all three outputs at the next falling edge, so each result is checked in the cycle it is due.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned N_FIXED = 4;
  localparam int unsigned SRC_W   = 3;

  localparam logic [SRC_W-1:0] SRC_DIV  = 3'd4;
  localparam logic [SRC_W-1:0] SRC_PREV = 3'd5;

  typedef enum logic [1:0] {
    REG_CFG = 2'd0,
    REG_PER = 2'd1,
    REG_WID = 2'd2,
    REG_DIV = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwm_div.sv
module pwm_div #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          base_tick_i,
  input  logic [DW-1:0] div_val_i,
  output logic          tick_o
);
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] last;

  assign last   = (div_val_i == '0) ? '0 : div_val_i - 1'b1;
  assign tick_o = base_tick_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (tick_o)      cnt_q <= '0;
    else if (base_tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_src_sel.sv
module pwm_src_sel #(
  parameter int unsigned N_FIXED = 4,
  parameter int unsigned SRC_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_FIXED-1:0] fixed_i,
  input  logic               div_tick_i,
  input  logic               prev_pwm_i,
  input  logic [SRC_W-1:0]   src_i,
  output logic               tick_o
);
  localparam int unsigned N_SRC = N_FIXED + 2;
  localparam int unsigned N_ALL = 1 << SRC_W;

  logic prev_q;
  logic prev_rise;
  logic [N_ALL-1:0] cand;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= prev_pwm_i;
  end

  assign prev_rise = prev_pwm_i & ~prev_q;

  for (genvar g = 0; g < N_ALL; g++) begin : g_cand
    if (g < N_FIXED) begin : g_fix
      assign cand[g] = fixed_i[g];
    end else if (g == N_FIXED) begin : g_div
      assign cand[g] = div_tick_i;
    end else if (g == N_SRC - 1) begin : g_prev
      assign cand[g] = prev_rise;
    end else begin : g_none
      assign cand[g] = 1'b0;
    end
  end

  assign tick_o = cand[src_i];
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [DW-1:0] period_i,
  input  logic [DW-1:0] width_i,
  output logic [DW-1:0] cnt_o,
  output logic          pwm_o
);
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] last;

  assign last = (period_i == '0) ? '0 : period_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_i) begin
      if (cnt_q >= last) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign pwm_o = cnt_q < width_i;
endmodule

// File: rtl/pwm_irq.sv
module pwm_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic rise_sel_i,
  input  logic allow_i,
  input  logic rd_i,
  input  logic mask_i,
  output logic stat_o,
  output logic req_o
);
  logic pwm_q;
  logic hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= pwm_i;
  end

  assign hit = allow_i && (rise_sel_i ? (pwm_i & ~pwm_q) : (~pwm_i & pwm_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   stat_o <= 1'b0;
    else if (hit)  stat_o <= 1'b1;
    else if (rd_i) stat_o <= 1'b0;
  end

  assign req_o = stat_o & mask_i;
endmodule

// File: rtl/pwm_clksel_chan.sv
module pwm_clksel_chan
  import pwm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_FIXED-1:0] tick_i,
  input  logic               prev_pwm_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [DW-1:0]      wr_data_i,
  input  logic               stat_rd_i,
  input  logic               int_mask_i,
  output logic               pwm_o,
  output logic               int_stat_o,
  output logic               int_req_o
);
  localparam logic [DW-1:0] DIV_IRQ = '1;

  logic [DW-1:0] cfg_q, per_q, wid_q, div_q;
  logic [DW-1:0] cnt_w;
  logic          div_tick, sel_tick, irq_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      per_q <= '1;
      wid_q <= '0;
      div_q <= '1;
    end else if (wr_en_i) begin
      unique case (reg_sel_e'(wr_sel_i))
        REG_CFG: cfg_q <= wr_data_i;
        REG_PER: per_q <= wr_data_i;
        REG_WID: wid_q <= wr_data_i;
        REG_DIV: div_q <= wr_data_i;
        default: ;
      endcase
    end
  end

  pwm_div #(.DW(DW)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .base_tick_i(tick_i[N_FIXED-1]),
    .div_val_i  (div_q),
    .tick_o     (div_tick)
  );

  pwm_src_sel #(.N_FIXED(N_FIXED), .SRC_W(SRC_W)) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fixed_i   (tick_i),
    .div_tick_i(div_tick),
    .prev_pwm_i(prev_pwm_i),
    .src_i     (cfg_q[SRC_W-1:0]),
    .tick_o    (sel_tick)
  );

  pwm_core #(.DW(DW)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (sel_tick),
    .period_i(per_q),
    .width_i (wid_q),
    .cnt_o   (cnt_w),
    .pwm_o   (pwm_o)
  );

  // interrupt only on the slow divider path at full divide
  assign irq_ok = (cfg_q[SRC_W-1:0] == SRC_DIV) && (div_q == DIV_IRQ);

  pwm_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwm_i     (pwm_o),
    .rise_sel_i(cfg_q[3]),
    .allow_i   (irq_ok),
    .rd_i      (stat_rd_i),
    .mask_i    (int_mask_i),
    .stat_o    (int_stat_o),
    .req_o     (int_req_o)
  );
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] cfg_i,
  input logic [DW-1:0] div_i,
  input logic [DW-1:0] wid_i,
  input logic [DW-1:0] cnt_i,
  input logic          pwm_i,
  input logic          stat_i,
  input logic          req_i,
  input logic          rd_i
);
  p_req_needs_stat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> stat_i);

  p_no_irq_other_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_i && !((cfg_i[2:0] == 3'd4) && (div_i == '1))) |=> !stat_i);

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i && !rd_i) |=> stat_i);

  p_zero_width_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wid_i == '0) |-> !pwm_i);

  p_hold_no_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[2:1] == 2'b11) |=> $stable(cnt_i));
endmodule

bind pwm_clksel_chan pwm_chan_chk #(.DW(pwm_pkg::DW)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .cfg_i (cfg_q),
  .div_i (div_q),
  .wid_i (wid_q),
  .cnt_i (cnt_w),
  .pwm_i (pwm_o),
  .stat_i(int_stat_o),
  .req_i (int_req_o),
  .rd_i  (stat_rd_i)
);

// File: tb/tb_pwm_clksel_chan.sv
module tb_pwm_clksel_chan;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] tick_i = '0;
  logic       prev_pwm_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       stat_rd_i = 1'b0;
  logic       int_mask_i = 1'b0;
  logic       pwm_o, int_stat_o, int_req_o;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit done = 0;

  // bench model state
  int m_cfg = 0, m_per = 255, m_wid = 0, m_div = 255;
  int m_dcnt = 0, m_cnt = 0;
  bit m_prevq = 0, m_pq = 0, m_stat = 0;
  bit seen_stat = 0;

  always #2 clk_i = ~clk_i;

  pwm_clksel_chan dut (.*);

  task automatic chk(input string t, input bit act, input bit exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", t, what, act, exp, $time);
    end
  endtask

  function automatic bit m_pwm();
    return m_cnt < m_wid;
  endfunction

  task automatic check_outs();
    chk(tag, pwm_o, m_pwm(), "pwm_o");
    chk(tag, int_stat_o, m_stat, "int_stat_o");
    chk("R10", int_req_o, m_stat & int_mask_i, "int_req_o");
    if (m_stat) seen_stat = 1;
  endtask

  // advance model by one rising edge using current inputs, then check
  task automatic step();
    int dv, pe, src;
    bit base, dtick, ptick, sel, pw, edge_hit, ok;
    base  = tick_i[3];
    dv    = (m_div == 0) ? 1 : m_div;
    dtick = base && (m_dcnt >= dv - 1);
    ptick = prev_pwm_i && !m_prevq;
    src   = m_cfg & 7;
    if (src < 4)       sel = tick_i[src];
    else if (src == 4) sel = dtick;
    else if (src == 5) sel = ptick;
    else               sel = 0;
    pe = (m_per == 0) ? 1 : m_per;
    pw = m_pwm();
    edge_hit = ((m_cfg >> 3) & 1) ? (pw && !m_pq) : (!pw && m_pq);
    ok = (src == 4) && (m_div == 255);
    if (base) m_dcnt = dtick ? 0 : m_dcnt + 1;
    if (sel)  m_cnt = (m_cnt >= pe - 1) ? 0 : m_cnt + 1;
    if (edge_hit && ok) m_stat = 1;
    else if (stat_rd_i) m_stat = 0;
    m_pq = pw;
    m_prevq = prev_pwm_i;
    if (wr_en_i) begin
      case (wr_sel_i)
        2'd0: m_cfg = wr_data_i;
        2'd1: m_per = wr_data_i;
        2'd2: m_wid = wr_data_i;
        default: m_div = wr_data_i;
      endcase
    end
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 0;
    stat_rd_i = 0;
    check_outs();
  endtask

  task automatic wr(input int sel, input int val);
    wr_en_i = 1; wr_sel_i = sel[1:0]; wr_data_i = val[7:0];
    step();
  endtask

  task automatic rnd_cycles(input int n, input int src_hi, input bit rnd_prev, input bit rnd_wr);
    for (int i = 0; i < n; i++) begin
      tick_i = 4'($urandom);
      prev_pwm_i = rnd_prev ? 1'($urandom) : 1'b0;
      int_mask_i = 1'($urandom);
      stat_rd_i = ($urandom % 8) == 0;
      if (rnd_wr && ($urandom % 32) == 0) begin
        wr_en_i = 1;
        wr_sel_i = 2'(1 + $urandom % 2);
        wr_data_i = 8'($urandom % 12);
      end
      step();
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    #1;
    // R1: reset state
    @(negedge clk_i);
    check_outs();
    rst_ni = 1;
    @(negedge clk_i);
    check_outs();

    // R5: width 0 gives constant low even on a fast source
    tag = "R5";
    wr(0, 1); wr(1, 5); wr(2, 0);
    tick_i = 4'hF;
    for (int i = 0; i < 40; i++) step();
    wr(2, 7);  // width above period: constant high
    for (int i = 0; i < 20; i++) step();

    // R2, R4, R11: fixed sources with random period/width writes
    for (int s = 0; s < 4; s++) begin
      tag = (s % 2) ? "R4" : "R2";
      wr(0, s); wr(1, 3 + s); wr(2, 1 + s);
      rnd_cycles(400, 3, 0, 1);
    end
    tag = "R11";
    wr(1, 0); wr(2, 1);  // period 0 acts as 1
    rnd_cycles(50, 3, 0, 0);

    // R3: divider source with small divide values
    tag = "R3";
    wr(0, 4); wr(3, 3); wr(1, 4); wr(2, 2);
    rnd_cycles(600, 3, 0, 0);
    wr(3, 0);
    rnd_cycles(200, 3, 0, 0);

    // R6: chained from previous channel
    tag = "R6";
    wr(0, 5); wr(3, 255); wr(1, 6); wr(2, 3);
    rnd_cycles(600, 3, 1, 1);

    // R2: codes 110 and 111 hold the counter
    tag = "R2";
    wr(0, 6); rnd_cycles(100, 3, 1, 0);
    wr(0, 7); rnd_cycles(100, 3, 1, 0);

    // R7, R9: falling-edge interrupt on divider at 255
    tag = "R7";
    wr(0, 4); wr(3, 255); wr(1, 2); wr(2, 1);
    for (int i = 0; i < 1800; i++) begin
      tick_i = 4'h8;
      int_mask_i = 1'($urandom);
      stat_rd_i = ($urandom % 64) == 0;
      step();
    end
    n_chk++;
    if (!seen_stat) begin
      n_fail++;
      $display("FAIL R7 status never set: actual 0 expected 1");
    end
    // rising edge selected
    tag = "R9";
    seen_stat = 0;
    wr(0, 8'h0C);
    for (int i = 0; i < 1800; i++) begin
      tick_i = 4'h8;
      int_mask_i = 1'b1;
      stat_rd_i = ($urandom % 64) == 0;
      step();
    end
    n_chk++;
    if (!seen_stat) begin
      n_fail++;
      $display("FAIL R9 status never set with rising edge: actual 0 expected 1");
    end

    // R8: no interrupt with divider 254 or a fast source
    tag = "R8";
    stat_rd_i = 1; step();
    wr(3, 254);
    for (int i = 0; i < 1500; i++) begin tick_i = 4'h8; int_mask_i = 1; step(); end
    wr(3, 255); wr(0, 3);
    for (int i = 0; i < 300; i++) begin tick_i = 4'hF; int_mask_i = 1; step(); end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule